// File: doc/BRIEF.md
# Dual-Rail Reset Supervisor

This block watches a set of regulator rails (two by default) and drives the pull-low enable of an open-drain, active-low system reset line. Each rail arrives as a single "in regulation" flag. Upstream window comparators already fold both the overvoltage and the undervoltage case into that flag, so a low flag means the rail is too high or too low. A short out-of-regulation blip is filtered out. A fault that lasts long enough pulls the line low, and the line stays low until every rail is back in regulation and the sequencing logic reports power-up complete.

Release is never immediate. Once all rails are good and power-up is complete, a release delay runs. Its length is a fixed base time plus a programmable extension, and the extension is captured when the delay starts. The rails dropping out again during the countdown sends it back to the start. A one-cycle expiry request, for example from a watchdog, forces the same timed low pulse while the line is released. All time is counted in clock cycles, using a cycles-per-microsecond parameter.

Top module: `rst_sup_top`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `rst_pull` is 1.
- R2: From the released state, any rail whose `rail_ok` bit is 0 for long enough sets `rst_pull` to 1. This applies to each rail on its own.
- R3: A fault (any `rail_ok` bit 0) is accepted only after it is present on G = GLITCH_US*CLK_PER_US consecutive clock edges. A fault lasting G-1 edges leaves `rst_pull` at 0. A fault lasting G edges sets `rst_pull` to 1 after the next edge.
- R4: The fault filter count returns to zero whenever all rails are in regulation on an edge, so separate short faults never add up.
- R5: With all rails good but `seq_done` low, `rst_pull` stays 1.
- R6: When the first edge sees all rails good with `seq_done` high while held, `rst_pull` falls exactly T = (BASE_US + `ext_us`)*CLK_PER_US edges later, counting that first edge as edge 0.
- R7: `ext_us` is captured when a delay starts. Later changes to it do not alter that delay.
- R8: During the release countdown, a single edge with any rail out of regulation (no filtering) abandons the count. The full delay T restarts once the rails are good again.
- R9: A `wd_req` pulse while released sets `rst_pull` to 1 from the next edge for exactly T edges. The line is then released if the rails are good and `seq_done` is high.
- R10: `wd_req` while `rst_pull` is 1 is ignored and does not change the release time.
- R11: `seq_done` falling while released sets `rst_pull` to 1 after the next edge, with no filtering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor |
| rail_ok | input | N_RAILS | Per-rail in-regulation flag, 1 = within window |
| seq_done | input | 1 | Power-up sequencing complete |
| wd_req | input | 1 | Expiry request forcing a timed reset pulse |
| ext_us | input | EXT_W | Delay extension in microseconds |
| rst_pull | output | 1 | Pull-low enable of the open-drain reset line, 1 = line held low |

## Verification
The bench targets the filter boundary by applying faults of exactly G-1 and G edges. A design that is off by one would either reset on a tolerated glitch or let a real fault through. It splits one long fault into two short ones with a single good edge between them, which catches a filter that accumulates instead of clearing. It changes `ext_us` in the middle of a countdown and breaks a countdown with a one-edge rail drop. A design that reads the extension live, or resumes rather than restarts, then releases at the wrong edge. Random episodes mix rail patterns, fault lengths and expiry pulses, and the exact release edge is checked each time, where a miscounted delay shows up directly.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  typedef enum logic [1:0] {
    SUP_HOLD  = 2'd0,  // line held, waiting for good rails
    SUP_COUNT = 2'd1,  // release delay running
    SUP_RUN   = 2'd2,  // line released
    SUP_PULSE = 2'd3   // forced pulse after an expiry request
  } sup_state_e;

  // total hold time in clock cycles for a given extension
  function automatic int unsigned sup_hold_cycles(input int unsigned base_us,
                                                  input int unsigned ext_us,
                                                  input int unsigned clk_per_us);
    return (base_us + ext_us) * clk_per_us;
  endfunction

endpackage

// File: rtl/rst_sup_filter.sv
module rst_sup_filter #(
  parameter int unsigned N_RAILS  = 2,
  parameter int unsigned FILT_CYC = 5000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_ok,
  output logic               any_out,
  output logic               fault_q
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] run_len;

  assign any_out = ~&rail_ok;
  assign fault_q = (run_len == CW'(FILT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (!any_out) run_len <= '0;
    else if (!fault_q) run_len <= run_len + CW'(1);
  end

  // R3: accepted fault only after an edge that saw a raw fault
  p_filt_needs_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(any_out));

  // R4: a good edge clears any accepted fault
  p_filt_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_out |=> !fault_q);

endmodule

// File: rtl/rst_sup_timer.sv
module rst_sup_timer
  import rst_sup_pkg::*;
#(
  parameter int unsigned EXT_W      = 16,
  parameter int unsigned CLK_PER_US = 250,
  parameter int unsigned BASE_US    = 10000,
  parameter int unsigned CNT_W      = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_out,
  input  logic             fault_q,
  input  logic             seq_done,
  input  logic             wd_req,
  input  logic [EXT_W-1:0] ext_us,
  output logic             rst_pull
);
  sup_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt;
  logic [CNT_W-1:0] new_tgt;
  logic             rails_good;
  logic             last_cyc;
  logic             busy;

  assign new_tgt    = CNT_W'(sup_hold_cycles(BASE_US, 32'(ext_us), CLK_PER_US));
  assign rails_good = !any_out && seq_done;
  assign last_cyc   = (cnt == tgt - CNT_W'(1));
  assign busy       = (state == SUP_COUNT) || (state == SUP_PULSE);
  assign rst_pull   = (state != SUP_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SUP_HOLD;
      cnt   <= '0;
      tgt   <= '0;
    end else begin
      unique case (state)
        SUP_HOLD: if (rails_good) begin
          state <= SUP_COUNT;
          cnt   <= '0;
          tgt   <= new_tgt;
        end
        SUP_COUNT: begin
          if (!rails_good)   state <= SUP_HOLD;
          else if (last_cyc) state <= SUP_RUN;
          else               cnt   <= cnt + CNT_W'(1);
        end
        SUP_RUN: begin
          if (fault_q || !seq_done) state <= SUP_HOLD;
          else if (wd_req) begin
            state <= SUP_PULSE;
            cnt   <= '0;
            tgt   <= new_tgt;
          end
        end
        SUP_PULSE: begin
          if (last_cyc) state <= rails_good ? SUP_RUN : SUP_HOLD;
          else          cnt   <= cnt + CNT_W'(1);
        end
        default: state <= SUP_HOLD;
      endcase
    end
  end

  // R2: accepted fault while released pulls the line
  p_fault_pulls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SUP_RUN && fault_q) |=> rst_pull);

  // R5: release only with sequencing complete
  p_release_needs_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pull) |-> $past(seq_done));

  // R6: release only at the end of a timed phase
  p_release_timed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pull) |-> $past(busy));

  // R6: running count stays below its target
  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < tgt));

  // R7: captured target does not move during a timed phase
  p_tgt_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt));

  // R8: a raw fault during countdown abandons it
  p_break_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SUP_COUNT && any_out) |=> (state == SUP_HOLD));

  // R10: no forced pulse starts while the countdown runs
  p_wd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SUP_COUNT && wd_req) |=> (state != SUP_PULSE));

  // R11: sequencing loss while released pulls the line
  p_seq_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SUP_RUN && !seq_done) |=> rst_pull);

endmodule

// File: rtl/rst_sup_top.sv
module rst_sup_top #(
  parameter int unsigned N_RAILS    = 2,
  parameter int unsigned CLK_PER_US = 250,
  parameter int unsigned GLITCH_US  = 20,
  parameter int unsigned BASE_US    = 10000,
  parameter int unsigned EXT_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_ok,
  input  logic               seq_done,
  input  logic               wd_req,
  input  logic [EXT_W-1:0]   ext_us,
  output logic               rst_pull
);
  localparam int unsigned FILT_CYC = GLITCH_US * CLK_PER_US;
  localparam int unsigned MAX_CYC  =
    rst_sup_pkg::sup_hold_cycles(BASE_US, (1 << EXT_W) - 1, CLK_PER_US);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic any_out;
  logic fault_q;

  rst_sup_filter #(
    .N_RAILS  (N_RAILS),
    .FILT_CYC (FILT_CYC)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .rail_ok (rail_ok),
    .any_out (any_out),
    .fault_q (fault_q)
  );

  rst_sup_timer #(
    .EXT_W      (EXT_W),
    .CLK_PER_US (CLK_PER_US),
    .BASE_US    (BASE_US),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_out  (any_out),
    .fault_q  (fault_q),
    .seq_done (seq_done),
    .wd_req   (wd_req),
    .ext_us   (ext_us),
    .rst_pull (rst_pull)
  );

  // R1: line held after a reset cycle
  p_reset_holds_r1: assert property (@(posedge clk)
    !rst_n |=> rst_pull);

endmodule

// File: tb/test_rst_sup_top.sv
`timescale 1ns/1ps
module test_rst_sup_top;
  localparam int CPU = 2;
  localparam int GUS = 3;
  localparam int BUS = 10;
  localparam int EW  = 4;
  localparam int G   = GUS * CPU;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    rail_ok = 2'b00;
  logic          seq_done = 1'b0;
  logic          wd_req = 1'b0;
  logic [EW-1:0] ext_us = '0;
  logic          rst_pull;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  rst_sup_top #(
    .N_RAILS(2), .CLK_PER_US(CPU), .GLITCH_US(GUS), .BASE_US(BUS), .EXT_W(EW)
  ) i_rst_sup_top (
    .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .seq_done(seq_done),
    .wd_req(wd_req), .ext_us(ext_us), .rst_pull(rst_pull)
  );

  function automatic int hold_len(input int e);
    return CPU * (e + BUS);
  endfunction

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_pull(input bit e, input string tag);
    n_chk++;
    if (rst_pull !== e) begin
      n_bad++;
      $display("FAIL %s: rst_pull=%0b expected %0b", tag, rst_pull, e);
    end
  endtask

  task automatic release_chk(input int t, input string tag);
    tick(t);
    expect_pull(1'b1, tag);
    tick(1);
    expect_pull(1'b0, tag);
  endtask

  task automatic rehold();
    seq_done = 1'b0;
    tick(1);
    seq_done = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    tick(3);
    expect_pull(1'b1, "R1 during reset");
    rst_n = 1'b1;
    tick(2);
    expect_pull(1'b1, "R1 after reset");

    rail_ok = 2'b11;
    tick(30);
    expect_pull(1'b1, "R5 seq not done");
    ext_us = 4'd5;
    seq_done = 1'b1;
    release_chk(hold_len(5), "R6 first release");

    seq_done = 1'b0;
    tick(1);
    expect_pull(1'b1, "R11 seq loss");
    seq_done = 1'b1;
    release_chk(hold_len(5), "R6 after seq loss");

    rail_ok = 2'b10;
    tick(G);
    expect_pull(1'b0, "R3 not yet accepted");
    tick(1);
    expect_pull(1'b1, "R2 rail0 fault");
    rail_ok = 2'b11;
    release_chk(hold_len(5), "R6 after rail0");

    rail_ok = 2'b01;
    tick(G);
    rail_ok = 2'b11;
    tick(1);
    expect_pull(1'b1, "R3 exactly G edges rail1");
    release_chk(hold_len(5), "R6 after rail1");

    rail_ok = 2'b00;
    tick(G - 1);
    rail_ok = 2'b11;
    tick(3);
    expect_pull(1'b0, "R3 G-1 glitch");

    rail_ok = 2'b10;
    tick(G - 1);
    rail_ok = 2'b11;
    tick(1);
    rail_ok = 2'b01;
    tick(G - 1);
    rail_ok = 2'b11;
    tick(2);
    expect_pull(1'b0, "R4 split glitches");

    rehold();
    ext_us = 4'd2;
    tick(3);
    ext_us = 4'd15;
    tick(hold_len(2) - 3);
    expect_pull(1'b1, "R7 late ext change");
    tick(1);
    expect_pull(1'b0, "R7 late ext change");

    rehold();
    ext_us = 4'd7;
    tick(10);
    rail_ok = 2'b10;
    tick(1);
    rail_ok = 2'b11;
    release_chk(hold_len(7), "R8 restart");

    rehold();
    ext_us = 4'd3;
    tick(4);
    wd_req = 1'b1;
    tick(1);
    wd_req = 1'b0;
    tick(hold_len(3) - 5);
    expect_pull(1'b1, "R10 wd during count");
    tick(1);
    expect_pull(1'b0, "R10 wd during count");

    ext_us = 4'd9;
    wd_req = 1'b1;
    tick(1);
    wd_req = 1'b0;
    expect_pull(1'b1, "R9 pulse start");
    release_chk(hold_len(9) - 1, "R9 pulse length");

    for (int it = 0; it < 30; it++) begin
      int mode;
      int e;
      logic [1:0] pat;
      mode = $urandom_range(0, 2);
      e    = $urandom_range(0, 15);
      pat  = 2'($urandom_range(0, 2));
      ext_us = e[EW-1:0];
      if (mode == 0) begin
        rail_ok = pat;
        tick($urandom_range(1, G - 1));
        rail_ok = 2'b11;
        tick(2);
        expect_pull(1'b0, "R3 random short glitch");
      end else if (mode == 1) begin
        int extra;
        extra = $urandom_range(0, 5);
        rail_ok = pat;
        tick(G);
        expect_pull(1'b0, "R3 random long fault");
        tick(1 + extra);
        expect_pull(1'b1, "R2 random long fault");
        rail_ok = 2'b11;
        release_chk(hold_len(e), "R6 random recovery");
      end else begin
        wd_req = 1'b1;
        tick(1);
        wd_req = 1'b0;
        release_chk(hold_len(e) - 1, "R9 random pulse");
      end
    end

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule